// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the state update a processor core needs when it enters an exception. The core presents a request carrying the faulting program counter, a cause code, an optional faulting virtual address, and a flag that marks the request as a debug entry. In one clock edge the block updates the status word, the saved program counters, the saved status words, the cause registers and the fault-address register. It then reports which handler class applies through a one-hot vector select that comes with a single-cycle taken pulse.

A general exception selects the kernel or user vector when the status word is not yet in exception mode. A second exception raised inside a handler selects the double-exception vector instead, and its program counter goes to a dedicated double-exception register. A debug entry is accepted only while the current interrupt level is below the configured debug level. The core loads the status word through a write port when it returns from a handler or changes mode. Saved program counters and status words are read back through a registered read port that is indexed by level.

Status word encoding used throughout: bits [2:0] hold the interrupt level, bit 3 is the user-mode bit and bit 4 is the exception-mode bit.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset the status word is 5'b10000 (level 0, user 0, exception mode 1). Taken, vector select, cause, debug cause, fault address and double-exception PC all read 0.
- R2: A general request accepted with exception mode 0 and user 0 gives vector select 4'b0001 (kernel) and stores the PC in saved-PC slot 1.
- R3: A general request accepted with exception mode 0 and user 1 gives vector select 4'b0010 (user) and stores the PC in saved-PC slot 1.
- R4: A general request accepted with exception mode 1 gives vector select 4'b0100 (double). With the double-exception register configured (default), the PC is stored there and slot 1 keeps its value. Without that register, the PC goes to slot 1.
- R5: Every accepted general request writes the cause code into the cause register and sets exception mode. The level and user bits keep their values.
- R6: An accepted general request with the address flag set writes the virtual address into the fault-address register. Without the flag, that register keeps its value.
- R7: A debug request is accepted only when the current level is below DBG_LEVEL. A rejected debug request produces no taken pulse and changes no state.
- R8: An accepted debug request gives vector select 4'b1000. It writes the debug cause, stores the PC in saved-PC slot DBG_LEVEL and the old status word in saved-status slot DBG_LEVEL, sets the level to DBG_LEVEL and sets exception mode. The user bit, the general cause and the fault address keep their values.
- R9: Taken is high for exactly one cycle per accepted request, the cycle after acceptance, and vector select is nonzero only in that cycle. A request presented while taken is high is not accepted; if it is still held, it is accepted on the next cycle.
- R10: The status write port loads the status word only in a cycle in which no request is accepted. An accepted entry takes priority over it.
- R11: The read port returns the saved PC and saved status of slot rd_idx one cycle after rd_idx is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Exception request present |
| req_debug | input | 1 | Request is a debug entry |
| req_has_addr | input | 1 | Request carries a faulting virtual address |
| req_pc | input | PC_W | Faulting program counter |
| req_cause | input | CAUSE_W | Cause code (general or debug) |
| req_vaddr | input | PC_W | Faulting virtual address |
| st_wr_en | input | 1 | Load the status word |
| st_wr_data | input | 5 | Status word to load |
| rd_idx | input | 3 | Saved-slot index to read |
| taken | output | 1 | Entry accepted last cycle |
| vec_sel | output | 4 | One-hot vector: 0 kernel, 1 user, 2 double, 3 debug |
| status | output | 5 | Current status word |
| cause | output | CAUSE_W | General cause register |
| fault_addr | output | PC_W | Fault-address register |
| dbg_cause | output | CAUSE_W | Debug cause register |
| depc | output | PC_W | Double-exception PC register |
| rd_pc | output | PC_W | Saved PC of the selected slot |
| rd_status | output | 5 | Saved status of the selected slot |

## Verification
A table of requests is applied from different preloaded status words. It covers a kernel entry, a user entry, an entry while already in exception mode, debug entries below and at the debug level, and requests with and without a fault address. Together these separate the four vector choices and show which registers each path may touch. Directed sequences then hold a request across the taken pulse, which distinguishes re-acceptance from a dropped request, and present a status write in the same cycle as an entry, which exposes a wrong priority. Slot read-back confirms where each PC and status word was stored, and that the slot-1 PC survives a double exception.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  localparam int ST_W     = 5;
  localparam int LVL_W    = 3;
  localparam int ST_USER  = 3;
  localparam int ST_EXC   = 4;
  localparam int VEC_N    = 4;

  typedef enum logic [1:0] {
    VEC_KERNEL = 2'd0,
    VEC_USER   = 2'd1,
    VEC_DOUBLE = 2'd2,
    VEC_DEBUG  = 2'd3
  } vec_e;

  function automatic logic [VEC_N-1:0] vec_onehot(input vec_e v);
    logic [VEC_N-1:0] r;
    r = '0;
    r[v] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/exc_decide.sv
module exc_decide
  import exc_seq_pkg::*;
#(
  parameter int DBG_LEVEL = 4,
  parameter bit HAS_DEPC  = 1'b1
) (
  input  logic             req_valid,
  input  logic             req_debug,
  input  logic             busy,
  input  logic [ST_W-1:0]  cur_status,
  output logic             accept,
  output vec_e             vec,
  output logic             save_en,
  output logic             save_st_en,
  output logic [LVL_W-1:0] save_idx,
  output logic             depc_en
);
  localparam logic [LVL_W-1:0] DBG_LVL = LVL_W'(DBG_LEVEL);
  localparam logic [LVL_W-1:0] SLOT_ONE = LVL_W'(1);

  logic [LVL_W-1:0] cur_lvl;
  logic             in_exc;
  logic             dbg_ok;
  logic             to_depc;

  always_comb begin
    cur_lvl = cur_status[LVL_W-1:0];
    in_exc  = cur_status[ST_EXC];
    dbg_ok  = cur_lvl < DBG_LVL;
    accept  = req_valid && !busy && (!req_debug || dbg_ok);

    if (req_debug)             vec = VEC_DEBUG;
    else if (in_exc)           vec = VEC_DOUBLE;
    else if (cur_status[ST_USER]) vec = VEC_USER;
    else                       vec = VEC_KERNEL;

    to_depc    = !req_debug && in_exc && HAS_DEPC;
    depc_en    = accept && to_depc;
    save_en    = accept && !to_depc;
    save_st_en = accept && req_debug;
    save_idx   = req_debug ? DBG_LVL : SLOT_ONE;
  end
endmodule

// File: rtl/exc_save_bank.sv
module exc_save_bank #(
  parameter int DEPTH = 5,
  parameter int PC_W  = 32,
  parameter int ST_W  = 5,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic             wr_st_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PC_W-1:0]  wr_pc,
  input  logic [ST_W-1:0]  wr_st,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [PC_W-1:0]  rd_pc,
  output logic [ST_W-1:0]  rd_st
);
  logic [PC_W-1:0] pc_mem [DEPTH];
  logic [ST_W-1:0] st_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en && (32'(wr_idx) < DEPTH))
      pc_mem[wr_idx] <= wr_pc;
    if (wr_st_en && (32'(wr_idx) < DEPTH))
      st_mem[wr_idx] <= wr_st;
  end

  always_ff @(posedge clk) begin
    if (32'(rd_idx) < DEPTH) begin
      rd_pc <= pc_mem[rd_idx];
      rd_st <= st_mem[rd_idx];
    end else begin
      rd_pc <= '0;
      rd_st <= '0;
    end
  end
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_seq_pkg::*;
#(
  parameter int DBG_LEVEL = 4,
  parameter int PC_W      = 32,
  parameter int CAUSE_W   = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               accept,
  input  logic               req_debug,
  input  logic               req_has_addr,
  input  logic [PC_W-1:0]    req_pc,
  input  logic [CAUSE_W-1:0] req_cause,
  input  logic [PC_W-1:0]    req_vaddr,
  input  vec_e               vec,
  input  logic               depc_en,
  input  logic               st_wr_en,
  input  logic [ST_W-1:0]    st_wr_data,
  output logic               taken,
  output logic [VEC_N-1:0]   vec_sel,
  output logic [ST_W-1:0]    status,
  output logic [CAUSE_W-1:0] cause,
  output logic [PC_W-1:0]    fault_addr,
  output logic [CAUSE_W-1:0] dbg_cause,
  output logic [PC_W-1:0]    depc
);
  localparam logic [LVL_W-1:0] DBG_LVL = LVL_W'(DBG_LEVEL);
  localparam logic [ST_W-1:0]  ST_RESET = ST_W'(1) << ST_EXC;

  always_ff @(posedge clk) begin
    if (rst) begin
      status     <= ST_RESET;
      cause      <= '0;
      fault_addr <= '0;
      dbg_cause  <= '0;
      depc       <= '0;
      taken      <= 1'b0;
      vec_sel    <= '0;
    end else begin
      taken   <= accept;
      vec_sel <= accept ? vec_onehot(vec) : '0;
      if (accept) begin
        status[ST_EXC] <= 1'b1;
        if (req_debug) begin
          dbg_cause            <= req_cause;
          status[LVL_W-1:0]    <= DBG_LVL;
        end else begin
          cause <= req_cause;
          if (req_has_addr) fault_addr <= req_vaddr;
          if (depc_en)      depc       <= req_pc;
        end
      end else if (st_wr_en) begin
        status <= st_wr_data;
      end
    end
  end

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    taken |=> !taken);
  assert_vec_with_taken_R9: assert property (@(posedge clk) disable iff (rst)
    $countones(vec_sel) == (taken ? 1 : 0));
  assert_exc_mode_set_R5: assert property (@(posedge clk) disable iff (rst)
    taken |-> status[ST_EXC]);
  assert_user_kept_R5: assert property (@(posedge clk) disable iff (rst)
    (taken && !vec_sel[VEC_DEBUG]) |-> (status[ST_USER] == $past(status[ST_USER])));
  assert_double_path_R4: assert property (@(posedge clk) disable iff (rst)
    vec_sel[VEC_DOUBLE] |-> $past(status[ST_EXC]));
  assert_debug_gate_R7: assert property (@(posedge clk) disable iff (rst)
    vec_sel[VEC_DEBUG] |-> ($past(status[LVL_W-1:0]) < DBG_LVL));
  assert_debug_level_R8: assert property (@(posedge clk) disable iff (rst)
    vec_sel[VEC_DEBUG] |-> (status[LVL_W-1:0] == DBG_LVL));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int DBG_LEVEL = 4,
  parameter int PC_W      = 32,
  parameter int CAUSE_W   = 6,
  parameter bit HAS_DEPC  = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_debug,
  input  logic               req_has_addr,
  input  logic [PC_W-1:0]    req_pc,
  input  logic [CAUSE_W-1:0] req_cause,
  input  logic [PC_W-1:0]    req_vaddr,
  input  logic               st_wr_en,
  input  logic [4:0]         st_wr_data,
  input  logic [2:0]         rd_idx,
  output logic               taken,
  output logic [3:0]         vec_sel,
  output logic [4:0]         status,
  output logic [CAUSE_W-1:0] cause,
  output logic [PC_W-1:0]    fault_addr,
  output logic [CAUSE_W-1:0] dbg_cause,
  output logic [PC_W-1:0]    depc,
  output logic [PC_W-1:0]    rd_pc,
  output logic [4:0]         rd_status
);
  localparam int SLOTS = DBG_LEVEL + 1;

  logic             accept;
  vec_e             vec;
  logic             save_en;
  logic             save_st_en;
  logic [LVL_W-1:0] save_idx;
  logic             depc_en;

  exc_decide #(.DBG_LEVEL(DBG_LEVEL), .HAS_DEPC(HAS_DEPC)) u_decide (
    .req_valid  (req_valid),
    .req_debug  (req_debug),
    .busy       (taken),
    .cur_status (status),
    .accept     (accept),
    .vec        (vec),
    .save_en    (save_en),
    .save_st_en (save_st_en),
    .save_idx   (save_idx),
    .depc_en    (depc_en)
  );

  exc_save_bank #(.DEPTH(SLOTS), .PC_W(PC_W), .ST_W(ST_W), .IDX_W(LVL_W)) u_bank (
    .clk      (clk),
    .wr_en    (save_en),
    .wr_st_en (save_st_en),
    .wr_idx   (save_idx),
    .wr_pc    (req_pc),
    .wr_st    (status),
    .rd_idx   (rd_idx),
    .rd_pc    (rd_pc),
    .rd_st    (rd_status)
  );

  exc_state_regs #(.DBG_LEVEL(DBG_LEVEL), .PC_W(PC_W), .CAUSE_W(CAUSE_W)) u_state (
    .clk          (clk),
    .rst          (rst),
    .accept       (accept),
    .req_debug    (req_debug),
    .req_has_addr (req_has_addr),
    .req_pc       (req_pc),
    .req_cause    (req_cause),
    .req_vaddr    (req_vaddr),
    .vec          (vec),
    .depc_en      (depc_en),
    .st_wr_en     (st_wr_en),
    .st_wr_data   (st_wr_data),
    .taken        (taken),
    .vec_sel      (vec_sel),
    .status       (status),
    .cause        (cause),
    .fault_addr   (fault_addr),
    .dbg_cause    (dbg_cause),
    .depc         (depc)
  );

  assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    taken |-> !accept);
  assert_st_write_yields_R10: assert property (@(posedge clk) disable iff (rst)
    (accept && st_wr_en) |=> status[ST_EXC]);
endmodule

// File: tb/exc_entry_seq_test.sv
`timescale 1ns/1ps
module exc_entry_seq_test;
  localparam int DBG = 4;

  typedef struct packed {
    logic [4:0]  st;
    logic        dbg;
    logic        ha;
    logic [31:0] pc;
    logic [5:0]  cause;
    logic [31:0] va;
    logic [3:0]  evec;
    logic [4:0]  est;
  } row_t;

  localparam row_t TBL [8] = '{
    '{5'b00000, 1'b0, 1'b1, 32'h0000_1000, 6'h03, 32'hAAAA_0000, 4'b0001, 5'b10000},
    '{5'b01000, 1'b0, 1'b0, 32'h0000_2000, 6'h05, 32'h1111_1111, 4'b0010, 5'b11000},
    '{5'b10000, 1'b0, 1'b1, 32'h0000_3000, 6'h09, 32'hBBBB_0004, 4'b0100, 5'b10000},
    '{5'b00010, 1'b1, 1'b0, 32'h0000_4000, 6'h02, 32'h0000_0000, 4'b1000, 5'b10100},
    '{5'b00100, 1'b1, 1'b0, 32'h0000_5000, 6'h01, 32'h0000_0000, 4'b0000, 5'b00100},
    '{5'b01011, 1'b1, 1'b1, 32'h0000_6000, 6'h04, 32'hCCCC_0000, 4'b1000, 5'b11100},
    '{5'b00011, 1'b0, 1'b0, 32'h0000_7000, 6'h3F, 32'hDDDD_0000, 4'b0001, 5'b10011},
    '{5'b11011, 1'b0, 1'b1, 32'h0000_8000, 6'h07, 32'hEEEE_0000, 4'b0100, 5'b11011}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_debug, req_has_addr;
  logic [31:0] req_pc, req_vaddr;
  logic [5:0]  req_cause;
  logic        st_wr_en;
  logic [4:0]  st_wr_data;
  logic [2:0]  rd_idx;
  logic        taken;
  logic [3:0]  vec_sel;
  logic [4:0]  status;
  logic [5:0]  cause, dbg_cause;
  logic [31:0] fault_addr, depc, rd_pc;
  logic [4:0]  rd_status;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [5:0]  m_cause, m_dbgc;
  logic [31:0] m_fault, m_depc, m_slot1;

  always #4 clk = ~clk;

  exc_entry_seq #(.DBG_LEVEL(DBG)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_debug(req_debug),
    .req_has_addr(req_has_addr), .req_pc(req_pc), .req_cause(req_cause),
    .req_vaddr(req_vaddr), .st_wr_en(st_wr_en), .st_wr_data(st_wr_data),
    .rd_idx(rd_idx), .taken(taken), .vec_sel(vec_sel), .status(status),
    .cause(cause), .fault_addr(fault_addr), .dbg_cause(dbg_cause), .depc(depc),
    .rd_pc(rd_pc), .rd_status(rd_status)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_debug = 1'b0; req_has_addr = 1'b0;
    req_pc = '0; req_vaddr = '0; req_cause = '0;
    st_wr_en = 1'b0; st_wr_data = '0; rd_idx = '0;
    m_cause = '0; m_dbgc = '0; m_fault = '0; m_depc = '0; m_slot1 = '0;
    @(negedge clk); tick(); tick();
    rst = 1'b0;
    // R1 reset state
    check("R1 status", 64'(status), 64'(5'b10000));
    check("R1 taken", 64'(taken), 64'd0);
    check("R1 vec", 64'(vec_sel), 64'd0);
    check("R1 cause", 64'(cause), 64'd0);
    check("R1 fault", 64'(fault_addr), 64'd0);
    check("R1 dbgcause", 64'(dbg_cause), 64'd0);
    check("R1 depc", 64'(depc), 64'd0);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R11
    for (int i = 0; i < 8; i++) begin
      row_t r;
      logic acc;
      r = TBL[i];
      st_wr_en = 1'b1; st_wr_data = r.st;
      tick();
      st_wr_en = 1'b0;
      req_valid = 1'b1; req_debug = r.dbg; req_has_addr = r.ha;
      req_pc = r.pc; req_cause = r.cause; req_vaddr = r.va;
      tick();
      req_valid = 1'b0;
      acc = (r.evec != 4'b0000);
      if (acc) begin
        if (r.dbg) m_dbgc = r.cause;
        else begin
          m_cause = r.cause;
          if (r.ha) m_fault = r.va;
          if (r.evec[2]) m_depc = r.pc;
          else m_slot1 = r.pc;
        end
      end
      check($sformatf("R2/R3/R4/R8 row%0d vec", i), 64'(vec_sel), 64'(r.evec));
      check($sformatf("R7/R9 row%0d taken", i), 64'(taken), 64'(acc));
      check($sformatf("R5/R8 row%0d status", i), 64'(status), 64'(r.est));
      check($sformatf("R5 row%0d cause", i), 64'(cause), 64'(m_cause));
      check($sformatf("R6 row%0d fault", i), 64'(fault_addr), 64'(m_fault));
      check($sformatf("R8 row%0d dbgcause", i), 64'(dbg_cause), 64'(m_dbgc));
      check($sformatf("R4 row%0d depc", i), 64'(depc), 64'(m_depc));
      rd_idx = (acc && r.dbg) ? 3'(DBG) : 3'd1;
      tick();
      check($sformatf("R9 row%0d taken drop", i), 64'(taken), 64'd0);
      if (acc && r.dbg) begin
        check($sformatf("R8 R11 row%0d saved pc", i), 64'(rd_pc), 64'(r.pc));
        check($sformatf("R8 R11 row%0d saved status", i), 64'(rd_status), 64'(r.st));
      end else begin
        check($sformatf("R2 R4 R11 row%0d slot1", i), 64'(rd_pc), 64'(m_slot1));
      end
    end

    // R9 held request across the taken pulse
    st_wr_en = 1'b1; st_wr_data = 5'b00000;
    tick();
    st_wr_en = 1'b0;
    req_valid = 1'b1; req_debug = 1'b0; req_has_addr = 1'b0;
    req_pc = 32'h0000_9000; req_cause = 6'h02;
    tick();
    check("R9 first accept taken", 64'(taken), 64'd1);
    check("R9 first accept vec", 64'(vec_sel), 64'(4'b0001));
    tick();
    check("R9 blocked while busy", 64'(taken), 64'd0);
    tick();
    check("R9 held reaccepted taken", 64'(taken), 64'd1);
    check("R9 held reaccepted vec double", 64'(vec_sel), 64'(4'b0100));
    check("R4 depc from held", 64'(depc), 64'h0000_9000);
    req_valid = 1'b0;
    tick();

    // R10 entry beats a status write in the same cycle
    st_wr_en = 1'b1; st_wr_data = 5'b00000;
    tick();
    st_wr_data = 5'b01111;
    req_valid = 1'b1; req_pc = 32'h0000_A000; req_cause = 6'h06;
    tick();
    req_valid = 1'b0;
    check("R10 entry wins status", 64'(status), 64'(5'b10000));
    check("R10 entry wins vec", 64'(vec_sel), 64'(4'b0001));
    tick();
    st_wr_en = 1'b0;
    check("R10 write loads when idle", 64'(status), 64'(5'b01111));

    // R7 debug at level above DBG_LEVEL is ignored
    st_wr_en = 1'b1; st_wr_data = 5'b00101;
    tick();
    st_wr_en = 1'b0;
    req_valid = 1'b1; req_debug = 1'b1; req_pc = 32'h0000_B000; req_cause = 6'h11;
    tick();
    req_valid = 1'b0; req_debug = 1'b0;
    check("R7 rejected taken", 64'(taken), 64'd0);
    check("R7 rejected status", 64'(status), 64'(5'b00101));
    check("R7 rejected dbgcause", 64'(dbg_cause), 64'(m_dbgc));
    tick();

    done = 1'b1;
    finish_run();
  end
endmodule